// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a processor's virtual address into a physical address through a page map. The page map is held in on-chip registers and is indexed directly by virtual page number. The low-order bits of the address form the in-page offset and go through unchanged. The high-order bits select one page-map entry. If that entry is marked present, the physical address is the entry's physical page number placed above the original offset. If the entry is not present, the block reports a missing-page fault so that software can bring the page in.

Every successful store marks its page as modified. Software can then tell whether a page must be written out before its frame is reused. An optional per-page write-protect bit turns a store to a protected page into a protection fault, and the page is left unmodified. Fault-handling software uses a one-cycle write port to install or evict entries. It uses a combinational read port to inspect an entry, for example to check the modified bit before an eviction.

The translated address is available combinationally in the same cycle as the request. Registered result flags follow one cycle after each request strobe. On a fault, those registered outputs also give the faulting page number and whether the access was a store.

Top module: `page_xlate`

## Requirements
- R1: On a request to a present page, `xl_hit` is 1 and `xl_paddr` equals the page's frame number concatenated above the low OFF_W address bits. One cycle later `done_ok` is 1 and `done_paddr` holds that same address.
- R2: A request to a page whose present bit is 0 drives `xl_paddr` to 0. One cycle later `pg_fault` is 1 and `done_ok` is 0.
- R3: `done_ok`, `pg_fault` and `ro_fault` are all 0 in any cycle that does not directly follow a request strobe. A single strobe therefore produces a pulse exactly one cycle long.
- R4: When `pg_fault` or `ro_fault` is 1, `flt_vpn` holds the page number of the faulting request. `flt_store` is 1 for a store and 0 for a load.
- R5: A store that completes with `done_ok` sets that page's modified bit to 1. A load leaves the modified bit unchanged.
- R6: When RO_EN is 1, a store to a present page whose write-protect bit is 1 produces `ro_fault` and no `done_ok`, and it leaves the modified bit unchanged.
- R7: A handler write (`mw_en`=1) replaces the present, modified, write-protect and frame fields of entry `mw_vpn`. The new values appear on the read port after the next clock edge.
- R8: Reset clears every present bit, so every page faults until software installs it.
- R9: An entry whose present bit is 0 is ignored whatever its other fields hold. Its frame number may duplicate the frame of a present page, and a store to it does not set its modified bit.
- R10: If a handler write and a successful store address the same entry in the same cycle, the handler's field values are the ones kept.
- R11: A load from a write-protected present page translates normally with `done_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_store | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | VPN_W+OFF_W | Virtual address |
| xl_hit | output | 1 | Combinational: requested page is present |
| xl_paddr | output | PPN_W+OFF_W | Combinational physical address (0 on miss) |
| done_ok | output | 1 | Registered: request translated without fault |
| done_paddr | output | PPN_W+OFF_W | Registered physical address of the completed request |
| pg_fault | output | 1 | Registered: page not present |
| ro_fault | output | 1 | Registered: store to write-protected page |
| flt_vpn | output | VPN_W | Page number of the faulting request |
| flt_store | output | 1 | Access type of the faulting request |
| mw_en | input | 1 | Handler entry write enable |
| mw_vpn | input | VPN_W | Entry to write |
| mw_res | input | 1 | Present bit to write |
| mw_dirty | input | 1 | Modified bit to write |
| mw_ro | input | 1 | Write-protect bit to write |
| mw_ppn | input | PPN_W | Frame number to write |
| rd_vpn | input | VPN_W | Entry to read back |
| rd_res | output | 1 | Present bit of entry `rd_vpn` |
| rd_dirty | output | 1 | Modified bit of entry `rd_vpn` |
| rd_ro | output | 1 | Write-protect bit of entry `rd_vpn` |
| rd_ppn | output | PPN_W | Frame number of entry `rd_vpn` |

## Verification
The bench uses the default widths: an 8-bit offset, a 4-bit page number and a 3-bit frame number, with write protection enabled (RO_EN=1). With only 16 entries, it can walk the whole page map after reset and confirm that no page is present. With an 8-bit offset, addresses such as 0x2C8 split on a nibble boundary, so the expected physical addresses can be written down by hand. Because protection is enabled, the protection-fault path and the load-through-protected-page path are both reachable. The same small map also hosts a non-present entry that shares a frame with a present one, and a same-cycle collision between a handler write and a dirtying store.

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int OFF_W = 8,
  parameter int VPN_W = 4,
  parameter int PPN_W = 3,
  parameter bit RO_EN = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_store,
  input  logic [VPN_W+OFF_W-1:0] req_vaddr,
  output logic                   xl_hit,
  output logic [PPN_W+OFF_W-1:0] xl_paddr,
  output logic                   done_ok,
  output logic [PPN_W+OFF_W-1:0] done_paddr,
  output logic                   pg_fault,
  output logic                   ro_fault,
  output logic [VPN_W-1:0]       flt_vpn,
  output logic                   flt_store,
  input  logic                   mw_en,
  input  logic [VPN_W-1:0]       mw_vpn,
  input  logic                   mw_res,
  input  logic                   mw_dirty,
  input  logic                   mw_ro,
  input  logic [PPN_W-1:0]       mw_ppn,
  input  logic [VPN_W-1:0]       rd_vpn,
  output logic                   rd_res,
  output logic                   rd_dirty,
  output logic                   rd_ro,
  output logic [PPN_W-1:0]       rd_ppn
);
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int NPAGE = 1 << VPN_W;

  logic [NPAGE-1:0] res_q, dirty_q, ro_q;
  logic [PPN_W-1:0] ppn_q [NPAGE];

  logic [VPN_W-1:0] vpn;
  logic             prot_bit, store_ok, store_prot;

  assign vpn      = req_vaddr[VA_W-1:OFF_W];
  assign xl_hit   = res_q[vpn];
  assign xl_paddr = xl_hit ? {ppn_q[vpn], req_vaddr[OFF_W-1:0]} : '0;

  generate
    if (RO_EN) begin : g_prot
      assign prot_bit = ro_q[vpn];
    end else begin : g_noprot
      assign prot_bit = 1'b0;
    end
  endgenerate

  assign store_ok   = req_valid & req_store & xl_hit & ~prot_bit;
  assign store_prot = req_valid & req_store & xl_hit & prot_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      dirty_q <= '0;
      ro_q    <= '0;
      for (int i = 0; i < NPAGE; i++) ppn_q[i] <= '0;
    end else begin
      if (store_ok) dirty_q[vpn] <= 1'b1;
      if (mw_en) begin
        res_q[mw_vpn]   <= mw_res;
        dirty_q[mw_vpn] <= mw_dirty;
        ro_q[mw_vpn]    <= RO_EN ? mw_ro : 1'b0;
        ppn_q[mw_vpn]   <= mw_ppn;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_ok    <= 1'b0;
      pg_fault   <= 1'b0;
      ro_fault   <= 1'b0;
      done_paddr <= '0;
      flt_vpn    <= '0;
      flt_store  <= 1'b0;
    end else begin
      done_ok    <= req_valid & xl_hit & ~store_prot;
      pg_fault   <= req_valid & ~xl_hit;
      ro_fault   <= store_prot;
      done_paddr <= (req_valid & xl_hit & ~store_prot) ? xl_paddr : '0;
      if (req_valid & (~xl_hit | store_prot)) begin
        flt_vpn   <= vpn;
        flt_store <= req_store;
      end
    end
  end

  assign rd_res   = res_q[rd_vpn];
  assign rd_dirty = dirty_q[rd_vpn];
  assign rd_ro    = ro_q[rd_vpn];
  assign rd_ppn   = ppn_q[rd_vpn];

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |-> done_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])); // R1
  AST_MISS_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !res_q[vpn]) |=> (pg_fault && !done_ok)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(done_ok || pg_fault || ro_fault)); // R3
  AST_FAULT_VPN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !res_q[vpn]) |=> (flt_vpn == $past(vpn))); // R4
  AST_STORE_DIRTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && res_q[vpn] && !(RO_EN && ro_q[vpn]) && !mw_en)
      |=> dirty_q[$past(vpn)]); // R5
  AST_PROT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (RO_EN && req_valid && req_store && res_q[vpn] && ro_q[vpn])
      |=> (ro_fault && !done_ok)); // R6
  AST_INSTALL_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    mw_en |=> (res_q[$past(mw_vpn)] == $past(mw_res))); // R7
endmodule

// File: tb/page_xlate_tb.sv
`timescale 1ns/1ps
module page_xlate_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 0, req_store = 0;
  logic [11:0] req_vaddr = '0;
  logic        xl_hit, done_ok, pg_fault, ro_fault, flt_store;
  logic [10:0] xl_paddr, done_paddr;
  logic [3:0]  flt_vpn;
  logic        mw_en = 0, mw_res = 0, mw_dirty = 0, mw_ro = 0;
  logic [3:0]  mw_vpn = '0, rd_vpn = '0;
  logic [2:0]  mw_ppn = '0, rd_ppn;
  logic        rd_res, rd_dirty, rd_ro;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  page_xlate u_dut (.*);

  // {store, vaddr, kind(0 ok,1 page fault,2 protect), expected paddr}
  localparam logic [25:0] VEC [8] = '{
    {1'b0, 12'h2C8, 2'd0, 11'h4C8},   // R1
    {1'b0, 12'hE10, 2'd0, 11'h510},   // R1
    {1'b0, 12'h600, 2'd1, 11'h000},   // R2
    {1'b0, 12'h3AA, 2'd1, 11'h000},   // R9 absent, frame shared with page E
    {1'b1, 12'h1FF, 2'd2, 11'h000},   // R6
    {1'b0, 12'h1FF, 2'd0, 11'h7FF},   // R11
    {1'b1, 12'h200, 2'd0, 11'h400},   // R5
    {1'b1, 12'h0FC, 2'd1, 11'h000}    // R2
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic install(input logic [3:0] v, input bit r, input bit d, input bit ro, input logic [2:0] p);
    @(negedge clk);
    mw_en = 1; mw_vpn = v; mw_res = r; mw_dirty = d; mw_ro = ro; mw_ppn = p;
    @(negedge clk);
    mw_en = 0;
  endtask

  task automatic access(input bit st, input logic [11:0] va);
    @(negedge clk);
    req_valid = 1; req_store = st; req_vaddr = va;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R3 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8: every page absent after reset
    for (int i = 0; i < 16; i++) begin
      rd_vpn = 4'(i); #1;
      chk(rd_res == 0, "R8 present after reset", rd_res, 0);
    end
    access(0, 12'h0FC);
    chk(pg_fault == 1 && done_ok == 0, "R8 fault after reset", {pg_fault, done_ok}, 2'b10);

    install(4'h2, 1, 0, 0, 3'd4);
    install(4'hE, 1, 0, 0, 3'd5);
    install(4'h3, 0, 0, 0, 3'd5);
    install(4'h1, 1, 0, 1, 3'd7);
    install(4'h6, 0, 0, 0, 3'd2);
    rd_vpn = 4'h1; #1;
    chk({rd_res, rd_dirty, rd_ro, rd_ppn} == {3'b101, 3'd7}, "R7 readback", {rd_res, rd_dirty, rd_ro, rd_ppn}, {3'b101, 3'd7});

    for (int k = 0; k < 8; k++) begin
      logic [25:0] v;
      v = VEC[k];
      @(negedge clk);
      req_valid = 1; req_store = v[25]; req_vaddr = v[24:13];
      #1;
      chk(xl_paddr == (v[12:11] == 2'd1 ? 11'h0 : (v[12:11] == 2'd0 ? v[10:0] : xl_paddr)),
          "R1/R2 comb paddr", xl_paddr, v[10:0]);
      @(negedge clk);
      req_valid = 0;
      chk({done_ok, pg_fault, ro_fault} == {v[12:11] == 2'd0, v[12:11] == 2'd1, v[12:11] == 2'd2},
          "R1/R2/R6 outcome", {done_ok, pg_fault, ro_fault}, {v[12:11] == 2'd0, v[12:11] == 2'd1, v[12:11] == 2'd2});
      if (v[12:11] == 2'd0) chk(done_paddr == v[10:0], "R1 paddr", done_paddr, v[10:0]);
      else chk(flt_vpn == v[24:21] && flt_store == v[25], "R4 fault info", {flt_vpn, flt_store}, {v[24:21], v[25]});
      @(negedge clk);
      chk({done_ok, pg_fault, ro_fault} == 3'b000, "R3 single pulse", {done_ok, pg_fault, ro_fault}, 0);
    end

    rd_vpn = 4'h2; #1; chk(rd_dirty == 1, "R5 store sets dirty", rd_dirty, 1);
    rd_vpn = 4'hE; #1; chk(rd_dirty == 0, "R5 load keeps clean", rd_dirty, 0);
    rd_vpn = 4'h1; #1; chk(rd_dirty == 0, "R6 protected stays clean", rd_dirty, 0);
    access(1, 12'h612);
    rd_vpn = 4'h6; #1; chk(rd_dirty == 0, "R9 absent store no dirty", rd_dirty, 0);

    // R10: handler write and dirtying store on page E in one cycle
    @(negedge clk);
    req_valid = 1; req_store = 1; req_vaddr = 12'hE40;
    mw_en = 1; mw_vpn = 4'hE; mw_res = 1; mw_dirty = 0; mw_ro = 0; mw_ppn = 3'd6;
    @(negedge clk);
    req_valid = 0; mw_en = 0;
    chk(done_ok == 1 && done_paddr == 11'h540, "R10 store used old entry", done_paddr, 11'h540);
    rd_vpn = 4'hE; #1;
    chk(rd_dirty == 0 && rd_ppn == 3'd6, "R10 handler wins", {rd_dirty, rd_ppn}, {1'b0, 3'd6});

    // R7: eviction then fault
    install(4'h2, 0, 0, 0, 3'd4);
    access(0, 12'h2C8);
    chk(pg_fault == 1, "R7 evicted page faults", pg_fault, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule